// File: doc/BRIEF.md
# Resistive Touch Measurement Sequencer

This block runs an automatic resistive touchscreen scan from a slow timebase tick (nominally 32768 Hz, supplied as a one-cycle pulse on `tick_i`). For every X/Y pair it walks a fixed list of phases. The timed phases last a programmed number of ticks. In each of the two convert phases it hands an external ADC a start strobe and waits for the ADC to report done. Four pairs form one measurement, and `pair_o` shows which pair is running. At the end of each touch-detect phase the block packs the two trimmed coordinates and the pen level into one 32-bit word and writes it into a small result FIFO.

The FIFO is read through a valid/ready stream. A word leaves on every clock edge where `rd_valid_o` and `rd_ready_i` are both high. `rd_ready_i` may be held high or low for any length of time. A low `rd_ready_i` never stalls the sequencer: if the FIFO is full when a word arrives, the word is dropped and the overrun flag is set instead. Status and the threshold interrupt are plain level outputs. Scanning runs for as long as the auto-enable input is high. When that input goes low, the sequencer finishes the phase it is in and then rests idle.

Top module: `tscan_seq`

## Requirements
- R1: After reset, `phase_o` is 0 (idle), `pair_o` is 0, `adc_start_o`, `rd_valid_o` and `irq_o` are low, and `status_o` reads 0x80.
- R2: The phase codes are 0 idle, 1 X settle, 2 X convert, 3 Y settle, 4 Y convert, 5 detect delay, 6 touch detect and 7 untouched wait. While auto-enable is high the sequencer steps through 1 to 7 in that order, goes from 7 back to 1, and leaves idle for 1 one cycle after auto-enable goes high.
- R3: The X settle and Y settle phases each last the settle length in ticks. The detect-delay, touch-detect and untouched-wait phases each last their own length in ticks. A length of 0 behaves as 1.
- R4: On entry to a convert phase, `adc_start_o` is high for exactly one cycle, with `adc_ch_o` set to 0 for X and 1 for Y. The phase ends on the edge where `adc_done_i` is high.
- R5: When touch detect ends, the block pushes one word. Bits 25:16 hold the X result, bits 9:0 hold the Y result, bit 31 is the inverse of `pen_down_i` at that edge (0 means the pen is down), and every other bit is 0.
- R6: A size code c clears the lowest c bits of the 10-bit sample. Codes above 9 act as 9, and code 0 keeps the full 10 bits.
- R7: `pair_o` is 0 in the first pair after leaving idle, counts up by one after each untouched wait, and wraps from 3 back to 0.
- R8: If auto-enable is low when a phase ends, the next phase is idle. A later restart begins again at pair 0.
- R9: The FIFO holds 8 words in first-in first-out order. When it is empty, `rd_valid_o` is low, `rd_data_o` is 0, and `rd_ready_i` changes nothing.
- R10: A word pushed while the FIFO is full is discarded and sets the overrun flag. The flag stays set until a read leaves the FIFO empty.
- R11: `status_o` bits 3:0 hold the entry count, bit 7 is the empty flag and bit 8 is the overrun flag. All other bits are 0.
- R12: `irq_o` is high exactly when `irq_lvl_i` is non-zero and the entry count is at least `irq_lvl_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle timebase pulse |
| auto_en_i | input | 1 | Keep scanning while high |
| settle_len_i | input | 8 | Settle phase length in ticks |
| dly_len_i | input | 8 | Detect-delay length in ticks |
| det_len_i | input | 8 | Touch-detect length in ticks |
| wait_len_i | input | 8 | Untouched-wait length in ticks |
| x_size_i | input | 4 | X sample-size code (10 minus bits) |
| y_size_i | input | 4 | Y sample-size code (10 minus bits) |
| irq_lvl_i | input | 4 | FIFO level that raises the interrupt, 0 disables it |
| pen_down_i | input | 1 | Pen-detect comparator, high when touched |
| adc_done_i | input | 1 | ADC conversion finished, data valid |
| adc_data_i | input | 10 | ADC result |
| phase_o | output | 3 | Current phase code |
| pair_o | output | 2 | Index of the X/Y pair within the measurement |
| adc_start_o | output | 1 | Convert strobe |
| adc_ch_o | output | 1 | Axis being converted, 0 X and 1 Y |
| rd_valid_o | output | 1 | FIFO holds a word |
| rd_ready_i | input | 1 | Reader takes the word on this edge |
| rd_data_o | output | 32 | Oldest packed word, 0 when empty |
| status_o | output | 32 | Count, empty and overrun flags |
| irq_o | output | 1 | Threshold interrupt |

## Verification
The assertions assume that `tick_i` is a one-cycle pulse and that `adc_done_i` is a single-cycle pulse. They also assume that `adc_done_i` arrives only after `adc_start_o`, inside the convert phase it answers. The bench respects these assumptions. It pulses the tick on every fourth cycle. Its ADC model answers each start exactly once, three cycles later. Inputs change only just after a rising edge or at a falling edge. The FIFO is read only while the sequencer is idle, so each word the bench expects is known before it is compared.

// File: rtl/tscan_pkg.sv
package tscan_pkg;
  localparam int SAMPLE_W = 10;
  localparam int WORD_W   = 32;
  localparam int X_LSB    = 16;
  localparam int PEN_BIT  = 31;
  localparam int PAIRS    = 4;
  localparam int PAIR_W   = $clog2(PAIRS);

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SET_X = 3'd1,
    PH_CNV_X = 3'd2,
    PH_SET_Y = 3'd3,
    PH_CNV_Y = 3'd4,
    PH_DLY   = 3'd5,
    PH_DET   = 3'd6,
    PH_WAIT  = 3'd7
  } phase_e;

  function automatic phase_e phase_after(input phase_e p);
    case (p)
      PH_SET_X: phase_after = PH_CNV_X;
      PH_CNV_X: phase_after = PH_SET_Y;
      PH_SET_Y: phase_after = PH_CNV_Y;
      PH_CNV_Y: phase_after = PH_DLY;
      PH_DLY:   phase_after = PH_DET;
      PH_DET:   phase_after = PH_WAIT;
      default:  phase_after = PH_SET_X;
    endcase
  endfunction
endpackage

// File: rtl/tscan_trim.sv
module tscan_trim #(
  parameter int DW = 10
) (
  input  logic [3:0]    code_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] dout_i
);
  localparam logic [3:0] MAX_SH = 4'(DW - 1);
  logic [3:0] sh;
  always_comb begin
    sh     = (code_i > MAX_SH) ? MAX_SH : code_i;
    dout_i = din_i & ({DW{1'b1}} << sh);
  end
endmodule

// File: rtl/tscan_phase_fsm.sv
module tscan_phase_fsm
  import tscan_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              auto_en_i,
  input  logic [LEN_W-1:0]  settle_len_i,
  input  logic [LEN_W-1:0]  dly_len_i,
  input  logic [LEN_W-1:0]  det_len_i,
  input  logic [LEN_W-1:0]  wait_len_i,
  input  logic              adc_done_i,
  output phase_e            phase_o,
  output logic              adc_start_o,
  output logic              adc_ch_o,
  output logic              cap_x_o,
  output logic              cap_y_o,
  output logic              push_o,
  output logic [PAIR_W-1:0] pair_o
);
  phase_e           phase;
  logic [LEN_W-1:0] tcnt;
  logic [LEN_W-1:0] cur_len;
  logic [LEN_W:0]   len_eff;
  logic             timed, conv, issued, tend, cend, pend;

  always_comb begin
    timed = 1'b1;
    unique case (phase)
      PH_SET_X, PH_SET_Y: cur_len = settle_len_i;
      PH_DLY:             cur_len = dly_len_i;
      PH_DET:             cur_len = det_len_i;
      PH_WAIT:            cur_len = wait_len_i;
      default: begin
        cur_len = '0;
        timed   = 1'b0;
      end
    endcase
    len_eff     = (cur_len == '0) ? (LEN_W+1)'(1) : {1'b0, cur_len};
    conv        = (phase == PH_CNV_X) || (phase == PH_CNV_Y);
    tend        = timed && tick_i && (({1'b0, tcnt} + 1'b1) >= len_eff);
    cend        = conv && issued && adc_done_i;
    pend        = tend || cend;
    adc_start_o = conv && !issued;
    adc_ch_o    = (phase == PH_CNV_Y);
    cap_x_o     = cend && (phase == PH_CNV_X);
    cap_y_o     = cend && (phase == PH_CNV_Y);
    push_o      = tend && (phase == PH_DET);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      tcnt   <= '0;
      issued <= 1'b0;
      pair_o <= '0;
    end else if (phase == PH_IDLE) begin
      pair_o <= '0;
      tcnt   <= '0;
      issued <= 1'b0;
      if (auto_en_i) phase <= PH_SET_X;
    end else if (pend) begin
      tcnt   <= '0;
      issued <= 1'b0;
      phase  <= auto_en_i ? phase_after(phase) : PH_IDLE;
      if (phase == PH_WAIT)
        pair_o <= (pair_o == PAIR_W'(PAIRS - 1)) ? '0 : pair_o + 1'b1;
    end else begin
      if (timed && tick_i) tcnt <= tcnt + 1'b1;
      if (adc_start_o) issued <= 1'b1;
    end
  end

  assign phase_o = phase;

  p_timed_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (timed && !tick_i) |=> (phase == $past(phase)));
  p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start_o |=> !adc_start_o);
  p_stop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && pend && !auto_en_i) |=> (phase == PH_IDLE));
  p_idle_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && auto_en_i) |=> (phase == PH_SET_X && pair_o == '0));
endmodule

// File: rtl/tscan_fifo.sv
module tscan_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [W-1:0]  wr_data_i,
  output logic          rd_valid_o,
  input  logic          rd_ready_i,
  output logic [W-1:0]  rd_data_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o,
  output logic          ovr_o
);
  localparam logic [CW-1:0] FULL_V = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_P = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          full, pop, push_ok;

  always_comb begin
    empty_o    = (count_o == '0);
    full       = (count_o == FULL_V);
    rd_valid_o = !empty_o;
    rd_data_o  = empty_o ? '0 : mem[rptr];
    pop        = rd_valid_o && rd_ready_i;
    push_ok    = wr_en_i && (!full || pop);
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= wr_data_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      count_o <= '0;
      ovr_o   <= 1'b0;
    end else begin
      if (push_ok) wptr <= (wptr == LAST_P) ? '0 : wptr + 1'b1;
      if (pop)     rptr <= (rptr == LAST_P) ? '0 : rptr + 1'b1;
      count_o <= count_o + CW'(push_ok) - CW'(pop);
      if (wr_en_i && !push_ok)
        ovr_o <= 1'b1;
      else if (pop && !push_ok && count_o == CW'(1))
        ovr_o <= 1'b0;
    end
  end

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= FULL_V);
  p_idle_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && !pop) |=> $stable(count_o));
  p_overrun_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && full && !pop) |=> (ovr_o && count_o == FULL_V));
  p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_o && !(pop && count_o == CW'(1))) |=> ovr_o);
endmodule

// File: rtl/tscan_seq.sv
module tscan_seq
  import tscan_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic                auto_en_i,
  input  logic [LEN_W-1:0]    settle_len_i,
  input  logic [LEN_W-1:0]    dly_len_i,
  input  logic [LEN_W-1:0]    det_len_i,
  input  logic [LEN_W-1:0]    wait_len_i,
  input  logic [3:0]          x_size_i,
  input  logic [3:0]          y_size_i,
  input  logic [CW-1:0]       irq_lvl_i,
  input  logic                pen_down_i,
  input  logic                adc_done_i,
  input  logic [SAMPLE_W-1:0] adc_data_i,
  output logic [2:0]          phase_o,
  output logic [PAIR_W-1:0]   pair_o,
  output logic                adc_start_o,
  output logic                adc_ch_o,
  output logic                rd_valid_o,
  input  logic                rd_ready_i,
  output logic [WORD_W-1:0]   rd_data_o,
  output logic [WORD_W-1:0]   status_o,
  output logic                irq_o
);
  phase_e              phase;
  logic                cap [2];
  logic                push;
  logic [SAMPLE_W-1:0] trimmed [2];
  logic [SAMPLE_W-1:0] axis_q [2];
  logic [WORD_W-1:0]   word;
  logic [CW-1:0]       count;
  logic                empty, ovr;

  tscan_phase_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk, .rst_n, .tick_i, .auto_en_i,
    .settle_len_i, .dly_len_i, .det_len_i, .wait_len_i,
    .adc_done_i,
    .phase_o(phase), .adc_start_o, .adc_ch_o,
    .cap_x_o(cap[0]), .cap_y_o(cap[1]), .push_o(push), .pair_o
  );

  for (genvar a = 0; a < 2; a++) begin : g_axis
    tscan_trim #(.DW(SAMPLE_W)) u_trim (
      .code_i (a == 0 ? x_size_i : y_size_i),
      .din_i  (adc_data_i),
      .dout_i (trimmed[a])
    );
    always_ff @(posedge clk) begin
      if (!rst_n)      axis_q[a] <= '0;
      else if (cap[a]) axis_q[a] <= trimmed[a];
    end
  end

  always_comb begin
    word                            = '0;
    word[PEN_BIT]                   = !pen_down_i;
    word[X_LSB +: SAMPLE_W]         = axis_q[0];
    word[SAMPLE_W-1:0]              = axis_q[1];
  end

  tscan_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
    .clk, .rst_n,
    .wr_en_i(push), .wr_data_i(word),
    .rd_valid_o, .rd_ready_i, .rd_data_o,
    .count_o(count), .empty_o(empty), .ovr_o(ovr)
  );

  always_comb begin
    status_o           = '0;
    status_o[CW-1:0]   = count;
    status_o[7]        = empty;
    status_o[8]        = ovr;
    irq_o              = (irq_lvl_i != '0) && (count >= irq_lvl_i);
    phase_o            = phase;
  end

  p_irq_level_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lvl_i == '0) |-> !irq_o);
  p_push_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (phase == PH_WAIT || phase == PH_IDLE));
endmodule

// File: tb/tscan_seq_test.sv
module tscan_seq_test;
  logic        clk = 0, rst_n = 0, tick_i = 0, auto_en_i = 0;
  logic [7:0]  settle_len_i = 2, dly_len_i = 3, det_len_i = 5, wait_len_i = 6;
  logic [3:0]  x_size_i = 0, y_size_i = 0, irq_lvl_i = 4;
  logic        pen_down_i = 1, adc_done_i = 0, rd_ready_i = 0;
  logic [9:0]  adc_data_i = 0;
  logic [2:0]  phase_o;
  logic [1:0]  pair_o;
  logic        adc_start_o, adc_ch_o, rd_valid_o, irq_o;
  logic [31:0] rd_data_o, status_o;

  tscan_seq uut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [31:0] mq[$];
  logic        exp_ovr = 0;
  int          pushes = 0, pairs_started = 0, cv = 0;
  logic [9:0]  lastx = 0, lasty = 0;
  logic [2:0]  prev_ph = 0;
  logic        ae_last = 0;
  int          tcount = 0;
  logic [1:0]  epair = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] msk(input logic [3:0] c);
    return 10'h3FF << ((c > 9) ? 9 : c);
  endfunction
  function automatic bit timed(input logic [2:0] p);
    return p == 1 || p == 3 || p == 5 || p == 6 || p == 7;
  endfunction
  function automatic int elen(input logic [2:0] p);
    int l;
    case (p)
      1, 3: l = settle_len_i;
      5: l = dly_len_i;
      6: l = det_len_i;
      default: l = wait_len_i;
    endcase
    return (l == 0) ? 1 : l;
  endfunction

  // timebase: one-cycle tick every fourth cycle
  initial forever begin
    repeat (3) @(posedge clk);
    #1 tick_i = 1;
    @(posedge clk);
    #1 tick_i = 0;
  end

  // phase monitor and expected-word model
  always @(negedge clk) if (rst_n) begin
    if (phase_o != prev_ph) begin
      logic [2:0] en;
      if (timed(prev_ph)) chk(tcount == elen(prev_ph), "R3 phase length", tcount, elen(prev_ph));
      en = !ae_last ? 3'd0 : (prev_ph == 7 || prev_ph == 0) ? 3'd1 : prev_ph + 3'd1;
      chk(phase_o == en, "R2/R8 next phase", phase_o, en);
      if (prev_ph == 6) begin
        logic [31:0] w;
        w = '0;
        w[31] = !pen_down_i;
        w[25:16] = lastx & msk(x_size_i);
        w[9:0] = lasty & msk(y_size_i);
        pushes++;
        if (mq.size() < 8) mq.push_back(w); else exp_ovr = 1;
      end
      if (phase_o == 1) begin
        logic [1:0] ep;
        ep = (prev_ph == 0) ? 2'd0 : epair + 2'd1;
        chk(pair_o == ep, "R7 pair index", pair_o, ep);
        epair = ep;
        pairs_started++;
        pen_down_i = (pairs_started % 3) != 2;
      end
      tcount = 0;
    end
    if (timed(phase_o) && tick_i) tcount++;
    prev_ph = phase_o;
    ae_last = auto_en_i;
  end

  // ADC model: answers each start three cycles later
  initial forever begin
    @(negedge clk);
    if (rst_n && adc_start_o) begin
      logic ch;
      logic [9:0] v;
      ch = adc_ch_o;
      chk((phase_o == 2 && !ch) || (phase_o == 4 && ch), "R4 start channel", {phase_o, ch}, 0);
      cv++;
      v = 10'((cv * 97 + 13) & 10'h3FF);
      @(negedge clk);
      chk(!adc_start_o, "R4 single start pulse", adc_start_o, 0);
      @(negedge clk);
      adc_done_i = 1;
      adc_data_i = v;
      if (ch) lasty = v; else lastx = v;
      @(negedge clk);
      adc_done_i = 0;
    end
  end

  task automatic run_pairs(input int n);
    int target;
    target = pushes + n;
    @(posedge clk); #1 auto_en_i = 1;
    while (pushes < target) @(negedge clk);
    @(posedge clk); #1 auto_en_i = 0;
    while (phase_o != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pop_one;
    @(negedge clk);
    chk(rd_valid_o, "R9 valid", rd_valid_o, 1);
    chk(rd_data_o == mq[0], "R5/R6 word", rd_data_o, mq[0]);
    chk(status_o == {23'd0, exp_ovr, 1'b0, 3'd0, 4'(mq.size())}, "R11 status", status_o,
        {23'd0, exp_ovr, 1'b0, 3'd0, 4'(mq.size())});
    chk(irq_o == (irq_lvl_i != 0 && mq.size() >= irq_lvl_i), "R12 irq", irq_o, 0);
    chk(status_o[8] == exp_ovr, "R10 overrun flag", status_o[8], exp_ovr);
    @(posedge clk); #1 rd_ready_i = 1;
    @(posedge clk); #1 rd_ready_i = 0;
    void'(mq.pop_front());
    if (mq.size() == 0) exp_ovr = 0;
  endtask

  task automatic drain;
    while (mq.size() > 0) pop_one();
    @(negedge clk);
    chk(!rd_valid_o && rd_data_o == 0, "R9 empty read", rd_data_o, 0);
    @(posedge clk); #1 rd_ready_i = 1;
    @(posedge clk); #1 rd_ready_i = 0;
    @(negedge clk);
    chk(status_o == 32'h80, "R9/R10 empty after ready", status_o, 32'h80);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(phase_o == 0 && pair_o == 0 && !adc_start_o, "R1 reset phase", phase_o, 0);
    chk(!rd_valid_o && !irq_o && status_o == 32'h80, "R1 reset status", status_o, 32'h80);
    // threshold at four entries
    run_pairs(3);
    chk(!irq_o && status_o[3:0] == 3, "R12 below threshold", {irq_o, status_o[3:0]}, 3);
    run_pairs(1);
    chk(irq_o && status_o[3:0] == 4, "R12 at threshold", {irq_o, status_o[3:0]}, 5'h14);
    drain();
    // stop in the middle of a pair, then restart at pair 0
    @(posedge clk); #1 auto_en_i = 1;
    while (phase_o != 3) @(negedge clk);
    @(posedge clk); #1 auto_en_i = 0;
    while (phase_o != 0) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(phase_o == 0, "R8 stays idle", phase_o, 0);
    run_pairs(2);
    drain();
    // sample-size sweep, including a clamped code
    for (int c = 0; c <= 12; c++) begin
      x_size_i = 4'(c);
      y_size_i = 4'((c <= 10) ? 10 - c : 0);
      run_pairs(1);
      drain();
    end
    x_size_i = 0; y_size_i = 0;
    // phase-length sweep, including zero lengths
    for (int s = 0; s < 4; s++) begin
      settle_len_i = 8'(s); dly_len_i = 8'(3 - s); det_len_i = 8'(s + 1); wait_len_i = 8'(s);
      run_pairs(1);
      drain();
    end
    // overrun: ten pushes into eight slots
    irq_lvl_i = 6;
    run_pairs(10);
    chk(status_o[8] && status_o[3:0] == 8, "R10 overrun set", status_o, 32'h108);
    drain();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule